// File: doc/BRIEF.md
# Set-Associative Tag Pipeline

This block keeps the tag store of a four-way set-associative read cache. It performs one tag operation on every clock, and each operation takes the same path through a short fixed pipeline. An operation is a lookup, a line fill (tag write), or a line invalidate. Write traffic reaches the cache as invalidates, because write data is never cached: a write that hits a line removes that line, and a write that misses changes nothing.

Each result reports three things. The first is whether the address hit. The second is which way holds the line. The third is the way that a fill of this set would replace next. That replacement choice takes an invalid way first and otherwise follows a three-bit tree pseudo-LRU kept per set. Operations on the same set may follow one another on consecutive cycles. Each one sees the tag and replacement updates made by the one before it.

After reset the unit clears every set, one set per cycle, and holds its input not-ready until that sweep is done.

Top module: `l2tag_pipe`

## Requirements
- R1: After reset is released, `ready_o` stays low for exactly SETS (2^SET_W) clock edges and then stays high. Operations presented while `ready_o` is low are not accepted and produce no result. Once the sweep is done, every set holds no valid line.
- R2: An operation is accepted in a cycle where `valid_i` and `ready_o` are both high. Its result appears with `res_valid_o` high exactly two rising edges later, and `res_op_o` echoes the op code. One operation can be accepted on every cycle.
- R3: The address splits as line offset `addr_i[OFF_W-1:0]` (6 bits, 64-byte lines, ignored), set index `addr_i[OFF_W+SET_W-1:OFF_W]`, and tag (the remaining upper bits).
- R4: Op code 0 is a lookup. `res_hit_o` is 1 when a valid way of the indexed set holds the tag, and `res_way_o` then gives that way. On a miss `res_way_o` is 0 and the set is unchanged.
- R5: Op code 1 is a fill. On a miss it writes the tag into the way reported in `res_victim_o` and marks that way valid. On a hit it only refreshes the existing way, so no duplicate is made, and it reports hit and that way.
- R6: Op code 2 is an invalidate, which is also how writes are issued. On a hit it clears only the hit way's valid bit and reports hit and way. On a miss nothing changes.
- R7: `res_victim_o` reports the state before the operation. If any way of the set is invalid, it is the lowest-numbered invalid way.
- R8: When all four ways are valid, the victim comes from the tree bits {b2,b1,b0}. If b0=0 the victim is way b1 (0 or 1). If b0=1 the victim is way 2+b2. A lookup hit or a fill on way w points the tree away from w: for w<2 it sets b0=1 and b1=!w[0]; for w>=2 it sets b0=0 and b2=!w[0]. Invalidates and misses leave the tree unchanged.
- R9: An operation on the same set as the operation accepted one cycle (or more) earlier sees that operation's tag, valid and tree updates.
- R10: Op code 3 behaves exactly as a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present |
| ready_o | output | 1 | Unit accepts an operation (low during the reset sweep) |
| op_i | input | 2 | 0 lookup, 1 fill, 2 invalidate/write, 3 lookup |
| addr_i | input | ADDR_W | Byte address of the line |
| res_valid_o | output | 1 | Result present |
| res_op_o | output | 2 | Op code of the result |
| res_hit_o | output | 1 | Address found in a valid way |
| res_way_o | output | 2 | Hit way, 0 on a miss |
| res_victim_o | output | 2 | Replacement way before the operation |

## Verification
Every cycle, the assertions check the ready timing of the reset sweep, that ready stays high once raised, and that each accepted operation yields exactly one result two edges later carrying its op code. They also check that a miss reports way 0. Only the bench's scenarios can show which way a fill lands in, and the pseudo-LRU victim order across a sequence of hits. They alone also show that an invalidate removes a line while leaving its neighbours in place, and that back-to-back operations on one set see each other's updates through the forwarding path.

// File: rtl/l2tag_pkg.sv
package l2tag_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int PLRU_W = 3;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_FILL   = 2'd1,
    OP_INVAL  = 2'd2,
    OP_LOOK3  = 2'd3
  } tag_op_e;
endpackage

// File: rtl/l2tag_victim.sv
module l2tag_victim
  import l2tag_pkg::*;
(
  input  logic [WAYS-1:0]   vld_i,
  input  logic [PLRU_W-1:0] plru_i,
  output logic [WAY_W-1:0]  victim_o
);
  always_comb begin
    // tree choice, overridden by lowest invalid way
    victim_o = plru_i[0] ? {1'b1, plru_i[2]} : {1'b0, plru_i[1]};
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_i[w]) victim_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/l2tag_plru_upd.sv
module l2tag_plru_upd
  import l2tag_pkg::*;
(
  input  logic [PLRU_W-1:0] plru_i,
  input  logic              en_i,
  input  logic [WAY_W-1:0]  way_i,
  output logic [PLRU_W-1:0] plru_o
);
  always_comb begin
    plru_o = plru_i;
    if (en_i) begin
      if (!way_i[1]) begin
        plru_o[0] = 1'b1;
        plru_o[1] = ~way_i[0];
      end else begin
        plru_o[0] = 1'b0;
        plru_o[2] = ~way_i[0];
      end
    end
  end
endmodule

// File: rtl/l2tag_store.sv
module l2tag_store #(
  parameter int SET_W = 6,
  parameter int ENT_W = 87
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] rd_idx_i,
  output logic [ENT_W-1:0] rd_ent_o,
  input  logic             wr_en_i,
  input  logic [SET_W-1:0] wr_idx_i,
  input  logic [ENT_W-1:0] wr_ent_i,
  output logic             init_done_o
);
  localparam int SETS = 1 << SET_W;

  logic [ENT_W-1:0] mem_q [SETS];
  logic [SET_W-1:0] sweep_q;
  logic             done_q;
  logic             mem_we;
  logic [SET_W-1:0] mem_widx;
  logic [ENT_W-1:0] mem_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sweep_q <= '0;
      done_q  <= 1'b0;
    end else if (!done_q) begin
      sweep_q <= sweep_q + 1'b1;
      if (sweep_q == SET_W'(SETS - 1)) done_q <= 1'b1;
    end
  end

  assign mem_we    = !done_q || wr_en_i;
  assign mem_widx  = done_q ? wr_idx_i : sweep_q;
  assign mem_wdata = done_q ? wr_ent_i : '0;

  // one-cycle read; a same-edge write is not visible to the read
  always_ff @(posedge clk_i) begin
    if (mem_we) mem_q[mem_widx] <= mem_wdata;
    rd_ent_o <= mem_q[rd_idx_i];
  end

  assign init_done_o = done_q;
endmodule

// File: rtl/l2tag_pipe.sv
module l2tag_pipe
  import l2tag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 6,
  parameter int OFF_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              res_valid_o,
  output logic [1:0]        res_op_o,
  output logic              res_hit_o,
  output logic [WAY_W-1:0]  res_way_o,
  output logic [WAY_W-1:0]  res_victim_o
);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int ENT_W = PLRU_W + WAYS + WAYS * TAG_W;

  logic accept;
  logic init_done;

  logic             s1_vld_q;
  tag_op_e          s1_op_q;
  logic [TAG_W-1:0] s1_tag_q;
  logic [SET_W-1:0] s1_idx_q;

  logic             fw_vld_q;
  logic [SET_W-1:0] fw_idx_q;
  logic [ENT_W-1:0] fw_ent_q;

  logic [ENT_W-1:0] rd_ent, cur_ent, nxt_ent;
  logic [PLRU_W-1:0] cur_plru, nxt_plru;
  logic [WAYS-1:0]   cur_vld, nxt_vld;
  logic [WAYS-1:0][TAG_W-1:0] cur_tags, nxt_tags;

  logic [WAYS-1:0]  way_hit;
  logic             hit;
  logic [WAY_W-1:0] hit_way, victim, sel_way;
  logic             plru_en;

  assign ready_o = init_done;
  assign accept  = valid_i && ready_o;

  l2tag_store #(.SET_W(SET_W), .ENT_W(ENT_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (addr_i[OFF_W +: SET_W]),
    .rd_ent_o    (rd_ent),
    .wr_en_i     (s1_vld_q),
    .wr_idx_i    (s1_idx_q),
    .wr_ent_i    (nxt_ent),
    .init_done_o (init_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s1_op_q  <= OP_LOOKUP;
      s1_tag_q <= '0;
      s1_idx_q <= '0;
    end else begin
      s1_vld_q <= accept;
      if (accept) begin
        s1_op_q  <= tag_op_e'(op_i);
        s1_tag_q <= addr_i[ADDR_W-1 -: TAG_W];
        s1_idx_q <= addr_i[OFF_W +: SET_W];
      end
    end
  end

  // bypass the write made on the edge the SRAM was read
  assign cur_ent = (fw_vld_q && fw_idx_q == s1_idx_q) ? fw_ent_q : rd_ent;
  assign {cur_plru, cur_vld, cur_tags} = cur_ent;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = cur_vld[w] && (cur_tags[w] == s1_tag_q);
  end

  assign hit = |way_hit;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) hit_way = WAY_W'(w);
    end
  end

  l2tag_victim u_victim (
    .vld_i    (cur_vld),
    .plru_i   (cur_plru),
    .victim_o (victim)
  );

  assign sel_way = (s1_op_q == OP_FILL && !hit) ? victim : hit_way;
  assign plru_en = (s1_op_q == OP_FILL) ||
                   (hit && (s1_op_q == OP_LOOKUP || s1_op_q == OP_LOOK3));

  l2tag_plru_upd u_plru (
    .plru_i (cur_plru),
    .en_i   (plru_en),
    .way_i  (sel_way),
    .plru_o (nxt_plru)
  );

  always_comb begin
    nxt_vld  = cur_vld;
    nxt_tags = cur_tags;
    if (s1_op_q == OP_FILL) begin
      nxt_vld[sel_way]  = 1'b1;
      nxt_tags[sel_way] = s1_tag_q;
    end else if (s1_op_q == OP_INVAL && hit) begin
      nxt_vld[hit_way] = 1'b0;
    end
  end

  assign nxt_ent = {nxt_plru, nxt_vld, nxt_tags};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fw_vld_q     <= 1'b0;
      fw_idx_q     <= '0;
      fw_ent_q     <= '0;
      res_valid_o  <= 1'b0;
      res_op_o     <= '0;
      res_hit_o    <= 1'b0;
      res_way_o    <= '0;
      res_victim_o <= '0;
    end else begin
      fw_vld_q    <= s1_vld_q;
      res_valid_o <= s1_vld_q;
      if (s1_vld_q) begin
        fw_idx_q     <= s1_idx_q;
        fw_ent_q     <= nxt_ent;
        res_op_o     <= s1_op_q;
        res_hit_o    <= hit;
        res_way_o    <= hit ? hit_way : '0;
        res_victim_o <= victim;
      end
    end
  end
endmodule

// File: rtl/l2tag_pipe_chk.sv
module l2tag_pipe_chk #(
  parameter int SET_W = 6
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       ready_o,
  input logic [1:0] op_i,
  input logic       res_valid_o,
  input logic [1:0] res_op_o,
  input logic       res_hit_o,
  input logic [1:0] res_way_o
);
  localparam int SETS = 1 << SET_W;

  logic [SET_W:0] edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edges_q <= '0;
    else if (edges_q < (SET_W + 1)'(SETS)) edges_q <= edges_q + 1'b1;
  end

  p_sweep_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q < (SET_W + 1)'(SETS)) |-> !ready_o);

  p_sweep_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q >= (SET_W + 1)'(SETS)) |-> ready_o);

  p_ready_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  p_result_due_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && ready_o, 2) |-> res_valid_o);

  p_result_owed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(valid_i && ready_o, 2));

  p_op_echo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_op_o == $past(op_i, 2)));

  p_miss_way_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |-> (res_way_o == 2'd0));
endmodule

bind l2tag_pipe l2tag_pipe_chk #(.SET_W(SET_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .ready_o     (ready_o),
  .op_i        (op_i),
  .res_valid_o (res_valid_o),
  .res_op_o    (res_op_o),
  .res_hit_o   (res_hit_o),
  .res_way_o   (res_way_o)
);

// File: tb/l2tag_pipe_tb_top.sv
module l2tag_pipe_tb_top;
  localparam int ADDR_W = 32;
  localparam int SET_W  = 6;
  localparam int OFF_W  = 6;
  localparam int SETS   = 1 << SET_W;
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

  localparam logic [1:0] LK = 2'd0, FL = 2'd1, IV = 2'd2, L3 = 2'd3;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              valid_i;
  logic              ready_o;
  logic [1:0]        op_i;
  logic [ADDR_W-1:0] addr_i;
  logic              res_valid_o;
  logic [1:0]        res_op_o;
  logic              res_hit_o;
  logic [1:0]        res_way_o;
  logic [1:0]        res_victim_o;

  always #2 clk_i = ~clk_i;

  l2tag_pipe #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int n_iss = 0, n_res = 0;
  int a_cyc [256];
  int r_cyc [256], r_op [256], r_hit [256], r_way [256], r_vic [256];
  bit done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (rst_ni === 1'b1 && res_valid_o === 1'b1 && n_res < 256) begin
      r_cyc[n_res] = cyc;
      r_op[n_res]  = int'(res_op_o);
      r_hit[n_res] = int'(res_hit_o);
      r_way[n_res] = int'(res_way_o);
      r_vic[n_res] = int'(res_victim_o);
      n_res++;
    end
  end

  function automatic logic [ADDR_W-1:0] mk(int t, int s, int o);
    return {TAG_W'(t), SET_W'(s), OFF_W'(o)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] op, input logic [ADDR_W-1:0] a);
    valid_i = 1'b1;
    op_i    = op;
    addr_i  = a;
    if (ready_o) begin
      a_cyc[n_iss] = cyc;
      n_iss++;
    end
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    valid_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic res(input string req, input int i, input int hit, input int way, input int vic);
    chk({req, " hit"}, r_hit[i], hit);
    chk({req, " way"}, r_way[i], way);
    chk({req, " victim"}, r_vic[i], vic);
  endtask

  task automatic t_reset();
    int n = 0;
    chk("R1 ready in reset", int'(ready_o), 0);
    chk("R1 res_valid in reset", int'(res_valid_o), 0);
    rst_ni  = 1'b1;
    valid_i = 1'b1;
    op_i    = LK;
    addr_i  = mk(1, 0, 0);
    while (!ready_o && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
    valid_i = 1'b0;
    chk("R1 sweep length", n, SETS);
    idle(4);
    chk("R1 no result from ops during sweep", n_res, 0);
  endtask

  task automatic t_basic();
    int b = n_iss;
    put(FL, mk(1, 5, 0));
    put(LK, mk(1, 5, 6'h3f));
    put(LK, mk(1, 6, 0));
    put(LK, mk(2, 5, 0));
    put(LK, mk(7, 40, 9));
    idle(4);
    res("R5 R7 first fill miss", b, 0, 0, 0);
    res("R3 R9 lookup after fill, offset ignored", b + 1, 1, 0, 1);
    res("R3 other set misses", b + 2, 0, 0, 0);
    res("R4 R7 other tag misses", b + 3, 0, 0, 1);
    res("R1 swept set empty", b + 4, 0, 0, 0);
    chk("R2 op echo fill", r_op[b], 1);
  endtask

  task automatic t_plru();
    int b = n_iss;
    put(FL, mk(10, 9, 0));
    put(FL, mk(11, 9, 0));
    put(FL, mk(12, 9, 0));
    put(FL, mk(13, 9, 0));
    put(LK, mk(14, 9, 0));
    put(LK, mk(10, 9, 0));
    put(LK, mk(14, 9, 0));
    put(LK, mk(12, 9, 0));
    put(LK, mk(14, 9, 0));
    put(FL, mk(14, 9, 0));
    put(LK, mk(11, 9, 0));
    put(LK, mk(14, 9, 0));
    idle(4);
    res("R7 R9 fill A", b, 0, 0, 0);
    res("R7 R9 fill B", b + 1, 0, 0, 1);
    res("R7 R9 fill C", b + 2, 0, 0, 2);
    res("R7 R9 fill D", b + 3, 0, 0, 3);
    res("R8 full set victim", b + 4, 0, 0, 0);
    res("R8 hit way0", b + 5, 1, 0, 0);
    res("R8 victim after way0 hit", b + 6, 0, 0, 2);
    res("R8 hit way2", b + 7, 1, 2, 2);
    res("R8 victim after way2 hit", b + 8, 0, 0, 1);
    res("R5 R8 fill replaces victim", b + 9, 0, 0, 1);
    res("R5 R8 evicted tag misses", b + 10, 0, 0, 3);
    res("R5 R9 new tag present", b + 11, 1, 1, 3);
  endtask

  task automatic t_inval();
    int b = n_iss;
    put(IV, mk(12, 9, 0));
    put(LK, mk(12, 9, 0));
    put(LK, mk(10, 9, 0));
    put(IV, mk(11, 9, 0));
    put(LK, mk(13, 9, 0));
    put(FL, mk(15, 9, 0));
    put(LK, mk(15, 9, 0));
    idle(4);
    res("R6 write hit invalidates", b, 1, 2, 3);
    res("R6 R9 line gone next cycle", b + 1, 0, 0, 2);
    res("R6 neighbour way0 kept", b + 2, 1, 0, 2);
    res("R6 write miss no effect", b + 3, 0, 0, 2);
    res("R6 neighbour way3 kept", b + 4, 1, 3, 2);
    res("R7 fill takes freed way", b + 5, 0, 0, 2);
    res("R8 tree after invalidate", b + 6, 1, 2, 1);
  endtask

  task automatic t_refill();
    int b = n_iss;
    put(FL, mk(10, 9, 0));
    put(IV, mk(10, 9, 0));
    put(LK, mk(10, 9, 0));
    idle(4);
    res("R5 fill on hit refreshes", b, 1, 0, 1);
    res("R5 single copy invalidated", b + 1, 1, 0, 3);
    res("R5 no duplicate left", b + 2, 0, 0, 0);
  endtask

  task automatic t_alt_op();
    int b = n_iss;
    put(L3, mk(13, 9, 0));
    put(LK, mk(13, 9, 0));
    idle(4);
    res("R10 op3 lookup", b, 1, 3, 0);
    chk("R10 op3 echo", r_op[b], 3);
    res("R10 op3 left line valid", b + 1, 1, 3, 0);
  endtask

  task automatic t_latency();
    chk("R2 one result per op", n_res, n_iss);
    for (int i = 0; i < n_res; i++) chk("R2 latency", r_cyc[i] - a_cyc[i], 2);
  endtask

  initial begin
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    op_i    = LK;
    addr_i  = '0;
    repeat (3) @(negedge clk_i);
    t_reset();
    t_basic();
    t_plru();
    t_inval();
    t_refill();
    t_alt_op();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule